// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Staged Settings

This block drives four independent pulse-width-modulated outputs from a shared reference tick. The tick is a single-cycle clock enable at a fixed 1 MHz rate. Each channel counts prescaled ticks over a programmable period and holds its output at the active level for a programmable number of those ticks at the start of each period. The prescaler divides the tick by 1, 2, 4 or 8. A polarity bit selects whether the active level is high or low.

Software writes the settings through a word-addressed register interface. The write is a single-cycle strobe, and reads are combinational. Duty and control writes land only in shadow copies. A write to the period register arms a commit. The running channel then takes all of its shadow values at the end of the period it is in. The output therefore never shows a mix of old and new settings. A committed period of zero turns the channel off, and its output then stays low. An idle channel takes an armed commit on the next clock and starts counting from zero.

Top module: `pwm_shadow_ctrl`

## Requirements
- R1: After reset, all four outputs are low, every register reads zero and no channel is running.
- R2: The period register of channel c is at byte address 0x400+4c, the duty register at 0x420+4c and the control register at 0x440+4c. Period and duty hold 16 bits. A control read returns the prescale code in bits [1:0], polarity in bit 5 and the commit-pending flag in bit 8. Reads return the last written values. Any other address reads zero and ignores writes.
- R3: While running with period P and duty D, an output is active for the first min(D,P) prescaled ticks of every P-tick period and inactive for the rest. It changes only on a prescaled tick or a commit.
- R4: With control bits [1:0] = k, a channel advances one count every 2^k reference ticks.
- R5: With control bit 5 set, the active level is low and the inactive level is high.
- R6: Duty and control writes leave the output unchanged until a period write follows and the running period ends. A period write sets the pending flag, and the commit clears it.
- R7: When an idle channel has a pending commit, it commits on the next clock. Its count and prescaler restart at zero, so its first period starts in the active phase when D > 0.
- R8: When a zero period is committed, the running period completes. The output then stays low whatever the polarity bit says.
- R9: A duty value greater than or equal to the period keeps the output active for the whole period.
- R10: Channels are independent: a write to one channel does not change another channel's output or registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle reference enable at the fixed 1 MHz rate |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_out | output | 4 | Channel outputs, bit c is channel c |

## Verification
The assertions assume the following about the inputs:
- A write is a one-cycle strobe at a word-aligned address.
- The reference tick may arrive in any cycle, including back to back.

The stability property relies on these, because an output may then change only in the cycle after a prescaled tick or a commit. The stimulus writes only word-aligned addresses and mixes the twelve mapped registers with a few unmapped ones. It varies the tick density between always-on, sparse and paused. The pause holds a pending commit in place long enough to read the flag back.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

  localparam int unsigned CNT_W      = 16;
  localparam int unsigned DIV_W      = 2;
  localparam int unsigned PRE_W      = 3;
  localparam int unsigned PERIOD_OFS = 32'h400;
  localparam int unsigned DUTY_OFS   = 32'h420;
  localparam int unsigned CTRL_OFS   = 32'h440;
  localparam int unsigned CTRL_INV_BIT  = 5;
  localparam int unsigned CTRL_PEND_BIT = 8;

  typedef struct packed {
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] duty;
    logic [DIV_W-1:0] div;
    logic             inv;
  } pwm_cfg_t;

  // Byte address of one register of one channel.
  function automatic int unsigned reg_addr(input int unsigned ofs, input int unsigned ch);
    return ofs + 4 * ch;
  endfunction

  // Last prescaler count before a prescaled tick: 2^div - 1.
  function automatic logic [PRE_W-1:0] pre_last(input logic [DIV_W-1:0] div);
    return PRE_W'((1 << div) - 1);
  endfunction

  // Output level inside a running period.
  function automatic logic chan_level(input logic [CNT_W-1:0] pos,
                                      input logic [CNT_W-1:0] duty,
                                      input logic inv);
    return (pos < duty) ^ inv;
  endfunction

endpackage

// File: rtl/pwm_reg_bank.sv
module pwm_reg_bank
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic [NUM_CH-1:0]       commit,
  output pwm_cfg_t [NUM_CH-1:0]   shadow,
  output logic [NUM_CH-1:0]       period_wr,
  output logic [NUM_CH-1:0]       pending,
  output logic [DATA_W-1:0]       bus_rdata
);

  wire unused_wdata = ^bus_wdata;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(reg_addr(PERIOD_OFS, i));
    localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(reg_addr(DUTY_OFS, i));
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(reg_addr(CTRL_OFS, i));

    logic hit_duty, hit_ctrl;
    assign period_wr[i] = bus_wr && (bus_addr == A_PER);
    assign hit_duty     = bus_wr && (bus_addr == A_DUTY);
    assign hit_ctrl     = bus_wr && (bus_addr == A_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow[i]  <= '0;
        pending[i] <= 1'b0;
      end else begin
        if (period_wr[i]) shadow[i].period <= bus_wdata[CNT_W-1:0];
        if (hit_duty)     shadow[i].duty   <= bus_wdata[CNT_W-1:0];
        if (hit_ctrl) begin
          shadow[i].div <= bus_wdata[DIV_W-1:0];
          shadow[i].inv <= bus_wdata[CTRL_INV_BIT];
        end
        if (period_wr[i])   pending[i] <= 1'b1;
        else if (commit[i]) pending[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(reg_addr(PERIOD_OFS, i)))
        bus_rdata = DATA_W'(shadow[i].period);
      if (bus_addr == ADDR_W'(reg_addr(DUTY_OFS, i)))
        bus_rdata = DATA_W'(shadow[i].duty);
      if (bus_addr == ADDR_W'(reg_addr(CTRL_OFS, i))) begin
        bus_rdata[DIV_W-1:0]     = shadow[i].div;
        bus_rdata[CTRL_INV_BIT]  = shadow[i].inv;
        bus_rdata[CTRL_PEND_BIT] = pending[i];
      end
    end
  end

endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core
  import pwm_shadow_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ref_tick,
  input  pwm_cfg_t shadow,
  input  logic     pending,
  output logic     commit,
  output logic     boundary,
  output logic     ptick,
  output logic     running,
  output logic     pwm_o
);

  pwm_cfg_t         act;
  logic [CNT_W-1:0] pos;
  logic [PRE_W-1:0] pre;

  assign running  = (act.period != '0);
  assign ptick    = ref_tick && running && (pre == pre_last(act.div));
  assign boundary = ptick && (pos == act.period - CNT_W'(1));
  assign commit   = pending && (!running || boundary);
  assign pwm_o    = running && chan_level(pos, act.duty, act.inv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= '0;
      pos <= '0;
      pre <= '0;
    end else if (commit) begin
      act <= shadow;
      pos <= '0;
      pre <= '0;
    end else begin
      if (ref_tick && running) pre <= ptick ? '0 : pre + PRE_W'(1);
      if (ptick)               pos <= boundary ? '0 : pos + CNT_W'(1);
    end
  end

endmodule

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  pwm_cfg_t [NUM_CH-1:0] shadow;
  logic [NUM_CH-1:0] chan_commit, chan_boundary, chan_ptick, chan_running;
  logic [NUM_CH-1:0] chan_period_wr, chan_pending;

  pwm_reg_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .commit(chan_commit), .shadow(shadow),
    .period_wr(chan_period_wr), .pending(chan_pending), .bus_rdata(bus_rdata)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    pwm_chan_core u_core (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
      .shadow(shadow[i]), .pending(chan_pending[i]),
      .commit(chan_commit[i]), .boundary(chan_boundary[i]),
      .ptick(chan_ptick[i]), .running(chan_running[i]), .pwm_o(pwm_out[i])
    );
  end

endmodule

// File: rtl/pwm_shadow_checker.sv
module pwm_shadow_checker #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] period_wr,
  input logic [NUM_CH-1:0] pending,
  input logic [NUM_CH-1:0] commit,
  input logic [NUM_CH-1:0] ptick,
  input logic [NUM_CH-1:0] running,
  input logic [NUM_CH-1:0] pwm_out
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    a_r6_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
      period_wr[i] |=> pending[i]);

    a_r6_pending_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (commit[i] && !period_wr[i]) |=> !pending[i]);

    a_r7_idle_commit_next: assert property (@(posedge clk) disable iff (!rst_n)
      (pending[i] && !running[i] && !period_wr[i]) |=> !pending[i]);

    a_r3_stable_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      (!ptick[i] && !commit[i]) |=> $stable(pwm_out[i]));
  end

endmodule

bind pwm_shadow_ctrl pwm_shadow_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .period_wr(chan_period_wr), .pending(chan_pending),
  .commit(chan_commit), .ptick(chan_ptick), .running(chan_running), .pwm_out(pwm_out)
);

// File: tb/sim_pwm_shadow_ctrl.sv
`timescale 1ns/1ps
module sim_pwm_shadow_ctrl;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";
  bit tick_on = 1'b0;
  int tick_mod = 1;

  always #5 clk = ~clk;

  pwm_shadow_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  // Reference model state: s_* staged, m_* live.
  int s_per[NCH], s_duty[NCH], s_div[NCH], s_inv[NCH], s_pend[NCH];
  int m_per[NCH], m_duty[NCH], m_div[NCH], m_inv[NCH], m_pos[NCH], m_pre[NCH];

  function automatic int which_ch(input int a, input int base);
    if (a >= base && a < base + 4 * NCH && (a % 4) == 0) return (a - base) / 4;
    return -1;
  endfunction

  function automatic bit model_out(input int c);
    if (m_per[c] == 0) return 1'b0;
    return (m_pos[c] < m_duty[c]) ? (m_inv[c] == 0) : (m_inv[c] != 0);
  endfunction

  function automatic int model_rd(input int a);
    int c;
    c = which_ch(a, 'h400); if (c >= 0) return s_per[c];
    c = which_ch(a, 'h420); if (c >= 0) return s_duty[c];
    c = which_ch(a, 'h440); if (c >= 0) return s_div[c] | (s_inv[c] << 5) | (s_pend[c] << 8);
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        s_per[c] = 0; s_duty[c] = 0; s_div[c] = 0; s_inv[c] = 0; s_pend[c] = 0;
        m_per[c] = 0; m_duty[c] = 0; m_div[c] = 0; m_inv[c] = 0; m_pos[c] = 0; m_pre[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        int span;
        bit live, step, wrap, take;
        span = 1 << m_div[c];
        live = (m_per[c] != 0);
        step = ref_tick && live && (m_pre[c] == span - 1);
        wrap = step && (m_pos[c] == m_per[c] - 1);
        take = s_pend[c] && (!live || wrap);
        if (take) begin
          m_per[c] = s_per[c]; m_duty[c] = s_duty[c];
          m_div[c] = s_div[c]; m_inv[c] = s_inv[c];
          m_pos[c] = 0; m_pre[c] = 0; s_pend[c] = 0;
        end else begin
          if (ref_tick && live) m_pre[c] = (m_pre[c] + 1) % span;
          if (step) m_pos[c] = wrap ? 0 : m_pos[c] + 1;
        end
      end
      if (bus_wr) begin
        int a, c;
        a = int'(bus_addr);
        c = which_ch(a, 'h400);
        if (c >= 0) begin s_per[c] = int'(bus_wdata[15:0]); s_pend[c] = 1; end
        c = which_ch(a, 'h420);
        if (c >= 0) s_duty[c] = int'(bus_wdata[15:0]);
        c = which_ch(a, 'h440);
        if (c >= 0) begin s_div[c] = int'(bus_wdata[1:0]); s_inv[c] = int'(bus_wdata[5]); end
      end
    end
  end

  // Tick driver.
  initial forever begin
    @(negedge clk);
    ref_tick = tick_on && (($urandom % tick_mod) == 0);
  end

  // Continuous output comparison against the model.
  initial forever begin
    @(negedge clk); #1;
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        checks++;
        if (pwm_out[c] !== model_out(c)) begin
          errors++;
          $display("FAIL %s ch%0d output actual=%0b expected=%0b at %0t",
                   cur_tag, c, pwm_out[c], model_out(c), $time);
        end
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = 12'(a); bus_wdata = 32'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input string tag);
    @(negedge clk);
    bus_addr = 12'(a);
    #2;
    checks++;
    if (bus_rdata !== 32'(model_rd(a))) begin
      errors++;
      $display("FAIL %s read 0x%0h actual=0x%0h expected=0x%0h", tag, a, bus_rdata, model_rd(a));
    end
  endtask

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(1234);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;

    // R1: reset state
    cur_tag = "R1";
    chk(pwm_out == 4'b0, "R1 outputs low", int'(pwm_out), 0);
    for (int c = 0; c < NCH; c++) begin
      rd_chk('h400 + 4 * c, "R1");
      rd_chk('h420 + 4 * c, "R1");
      rd_chk('h440 + 4 * c, "R1");
    end

    // R2: map, readback, unmapped addresses
    cur_tag = "R2";
    for (int c = 0; c < NCH; c++) begin
      wr('h420 + 4 * c, 'hABC0 + c);
      wr('h440 + 4 * c, 'hFFFF_FFDC + c);
      rd_chk('h420 + 4 * c, "R2 duty");
      rd_chk('h440 + 4 * c, "R2 ctrl");
    end
    wr('h410, 'h1234); wr('h460, 'h55); wr('h3FC, 'h77); wr('h42C + 4, 'h9);
    rd_chk('h410, "R2 unmapped"); rd_chk('h460, "R2 unmapped");
    rd_chk('h3FC, "R2 unmapped"); rd_chk('h400, "R2 period untouched");
    chk(pwm_out == 4'b0, "R2 unmapped writes no output", int'(pwm_out), 0);

    // R3: basic duty/period, ticks every cycle
    cur_tag = "R3";
    tick_on = 1'b1; tick_mod = 1;
    wr('h440, 0); wr('h420, 2); wr('h400, 5);
    rd_chk('h400, "R3 period readback");
    idle(120);

    // R4: prescale by 8 on channel 1
    cur_tag = "R4";
    wr('h444, 3); wr('h424, 1); wr('h404, 3);
    idle(200);

    // R5: inverted polarity on channel 2
    cur_tag = "R5";
    wr('h448, 'h21); wr('h428, 3); wr('h408, 7);
    idle(150);

    // R6: staged duty without period write, then pending flag
    cur_tag = "R6";
    wr('h420, 4);
    idle(60);
    rd_chk('h440, "R6 no pending after duty write");
    tick_on = 1'b0; idle(2);
    wr('h400, 6);
    rd_chk('h440, "R6 pending set");
    begin
      logic [31:0] v;
      v = bus_rdata;
      chk(v[8] == 1'b1, "R6 pending bit8", int'(v[8]), 1);
    end
    tick_on = 1'b1;
    idle(80);
    rd_chk('h440, "R6 pending cleared");

    // R7: idle channel 3 starts immediately in the active phase
    cur_tag = "R7";
    tick_on = 1'b0; idle(2);
    wr('h44C, 0); wr('h42C, 3); wr('h40C, 6);
    idle(2); #1;
    chk(pwm_out[3] == 1'b1, "R7 first period active", int'(pwm_out[3]), 1);
    rd_chk('h44C, "R7 pending cleared on idle");
    tick_on = 1'b1;
    idle(40);

    // R9: duty above period on channel 1
    cur_tag = "R9";
    wr('h444, 0); wr('h424, 9); wr('h404, 4);
    idle(100);
    #1;
    chk(pwm_out[1] == 1'b1, "R9 full-period active", int'(pwm_out[1]), 1);

    // R8: zero period with inverted polarity on channel 0
    cur_tag = "R8";
    wr('h440, 'h20); wr('h400, 0);
    idle(100);
    #1;
    chk(pwm_out[0] == 1'b0, "R8 disabled output low", int'(pwm_out[0]), 0);
    rd_chk('h400, "R8 period reads zero");

    // R10: constrained random mix across channels
    cur_tag = "R10";
    for (int n = 0; n < 3000; n++) begin
      int sel, c, a, d;
      if ((n % 500) == 0) tick_mod = 1 + ($urandom % 4);
      sel = $urandom % 8;
      c = $urandom % NCH;
      case (sel)
        0: begin a = 'h400 + 4 * c; d = $urandom % 10; end
        1: begin a = 'h420 + 4 * c; d = $urandom % 14; end
        2: begin a = 'h440 + 4 * c; d = $urandom; end
        3: begin a = 'h410 + 4 * ($urandom % 4); d = $urandom; end
        default: begin a = -1; d = 0; end
      endcase
      if (a >= 0) wr(a, d);
      else idle(1 + ($urandom % 6));
      if (($urandom % 4) == 0) rd_chk('h400 + 4 * ($urandom % 28), "R10 readback");
    end
    idle(300);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule